// File: doc/BRIEF.md
# Multi-Rail Power-Up Sequencer

This block turns a set of supply rails on in a controlled order and holds the system in reset until those rails are good. Each rail has a start rule. An absolute rail waits a fixed number of millisecond ticks after the start request. A relative rail waits until a chosen prerequisite rail reports good power, then waits its own delay. Once a rail's enable is high, the rail must report good power within its timeout. If it does not, the sequence freezes and the failing rail is named. A rail that is waiting on a prerequisite also times out if the prerequisite stays enabled but never reports good power.

System reset is released only after every rail in the required set has shown good power, without a break, for a release window. If any required rail loses good power after release, reset is asserted again and the window starts over. A shutdown request asserts reset first. It then drops the enables one at a time, a fixed number of ticks apart, in a programmed order (or in reverse index order if the mirror variant is chosen). After the last enable falls, the block returns to idle.

All inputs and outputs are plain level control and status pins with no data stream, so no valid/ready handshake applies. The power-good inputs are expected to be already qualified, synchronous to `clk`. `tick_ms` is a one-cycle pulse once per millisecond. Every delay, timeout and window is counted in these ticks.

Top module: `rail_sequencer`

## Requirements
- R1: An absolute rail (bit clear in `RELATIVE_MASK`) raises its enable on the tick that completes its `DELAY_TICKS` count, with ticks counted from the start request.
- R2: A relative rail raises its enable on the tick that completes its `DELAY_TICKS` count. Counting begins once its prerequisite rail (field `i` of `DEP_RAIL`) shows good power. A prerequisite that has not yet been enabled is legal.
- R3: While a relative rail waits, each tick on which its prerequisite is enabled but not good is counted. Reaching the rail's own `TIMEOUT_TICKS` is a timeout fault of the waiting rail.
- R4: An enabled rail that has not yet shown good power times out after `TIMEOUT_TICKS` ticks. The fault then does the following:
  - `fault_timeout` is set and `fault_rail` carries the rail index, with the lowest index winning if several rails time out together.
  - Reset is held.
  - No further enable rises until shutdown.
- R5: `sys_rst_n` rises once every rail set in `REQUIRED` has been good for `RELEASE_TICKS` consecutive ticks. Rails outside `REQUIRED` have no effect on it.
- R6: After release, a required rail losing good power drives `sys_rst_n` low on the next clock edge, and the full release window must pass again.
- R7: `seq_done` is high exactly while the sequence is powering up or running with every enable high and reset released.
- R8: A shutdown request drives `sys_rst_n` low on the next edge while the enables stay unchanged. Then one enable falls per `PD_GAP_TICKS` ticks, in the order listed in `PD_ORDER` (step 0 in the low field), and the block returns to idle.
- R9: Under `rst_n` low, and right after it, all enables are low, `sys_rst_n` is low, and `fault_timeout` and `seq_done` are low.
- R10: `fault_timeout` and `fault_rail` stay set through shutdown and idle, and clear when the next start request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset of the block |
| tick_ms | input | 1 | One-cycle pulse per millisecond; time base for all counts |
| seq_start | input | 1 | Start request, accepted in idle |
| seq_shutdown | input | 1 | Shutdown request, accepted while powering up or halted |
| rail_pg | input | N_RAILS | Qualified power-good per rail |
| rail_en | output | N_RAILS | Enable per rail |
| sys_rst_n | output | 1 | System reset, active low |
| fault_timeout | output | 1 | A rail timed out; sticky until next start |
| fault_rail | output | $clog2(N_RAILS) | Index of the rail that timed out |
| seq_done | output | 1 | All rails enabled and reset released |

## Verification
A wrong internal state shows up at the ports within one tick. A rail delay counter that slips moves that rail's enable edge by a whole tick, and it also shifts every relative rail chained behind it. A timeout counter that slips moves the tick on which `fault_timeout` appears, or hides the fault entirely. A release counter that slips makes `sys_rst_n` rise one tick early or late. A shutdown step pointer that slips makes the wrong enable fall, or makes it fall at the wrong step. The sweep varies the power-good latency of the first two rails across the timeout boundaries. It then compares each enable, the reset, the done flag and the fault outputs after every tick against arithmetic expectations.

// File: rtl/psq_pkg.sv
`timescale 1ns/1ps
package psq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_UP   = 2'd1,
    ST_HALT = 2'd2,
    ST_DOWN = 2'd3
  } seq_st_t;

  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_WAIT = 2'd1,
    RS_DLY  = 2'd2,
    RS_ON   = 2'd3
  } rail_st_t;
endpackage

// File: rtl/psq_rail.sv
`timescale 1ns/1ps
module psq_rail
  import psq_pkg::*;
#(
  parameter int unsigned CW       = 8,
  parameter int unsigned DELAY    = 1,
  parameter int unsigned TIMEOUT  = 4,
  parameter bit          RELATIVE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic active,
  input  logic tick,
  input  logic dep_pg,
  input  logic dep_en,
  input  logic own_pg,
  output logic en_raw,
  output logic to_hit
);
  localparam logic [CW-1:0] DLY_LAST = CW'(DELAY - 1);
  localparam logic [CW-1:0] TO_LAST  = CW'(TIMEOUT - 1);

  rail_st_t      st;
  logic [CW-1:0] cnt;
  logic          seen;
  logic          trig;
  logic          wait_ct;
  logic          on_ct;

  assign trig    = RELATIVE ? dep_pg : 1'b1;
  // a waiting rail only spends its budget while the prerequisite is powered but not good
  assign wait_ct = RELATIVE && tick && dep_en && !dep_pg;
  assign on_ct   = tick && !seen && !own_pg;
  assign to_hit  = active && (cnt == TO_LAST) &&
                   (((st == RS_WAIT) && wait_ct) || ((st == RS_ON) && on_ct));
  assign en_raw  = (st == RS_ON);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      st   <= RS_IDLE;
      cnt  <= '0;
      seen <= 1'b0;
    end else if (active) begin
      unique case (st)
        RS_IDLE: begin
          st   <= RS_WAIT;
          cnt  <= '0;
          seen <= 1'b0;
        end
        RS_WAIT: begin
          if (trig) begin
            st  <= (DELAY == 0) ? RS_ON : RS_DLY;
            cnt <= '0;
          end else if (wait_ct) begin
            cnt <= cnt + 1'b1;
          end
        end
        RS_DLY: begin
          if (tick) begin
            if (cnt == DLY_LAST) begin
              st  <= RS_ON;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        RS_ON: begin
          if (own_pg) seen <= 1'b1;
          else if (on_ct) cnt <= cnt + 1'b1;
        end
        default: st <= RS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/psq_rstgate.sv
`timescale 1ns/1ps
module psq_rstgate #(
  parameter int unsigned   N_RAILS = 4,
  parameter int unsigned   CW      = 8,
  parameter logic [N_RAILS-1:0] REQ = '1,
  parameter int unsigned   REL     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick,
  input  logic [N_RAILS-1:0] pg,
  output logic               rel_n
);
  localparam logic [CW-1:0] REL_LAST = CW'(REL - 1);

  logic          all_ok;
  logic [CW-1:0] cnt;

  assign all_ok = &(pg | ~REQ);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || !all_ok) begin
      rel_n <= 1'b0;
      cnt   <= '0;
    end else if (!rel_n) begin
      if (REL == 0) begin
        rel_n <= 1'b1;
      end else if (tick) begin
        if (cnt == REL_LAST) rel_n <= 1'b1;
        else cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/psq_pdown.sv
`timescale 1ns/1ps
module psq_pdown #(
  parameter int unsigned N_RAILS = 4,
  parameter int unsigned CW      = 8,
  parameter int unsigned GAP     = 2,
  parameter logic [N_RAILS*$clog2(N_RAILS)-1:0] ORDER = '0,
  parameter bit          MIRROR  = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               tick,
  output logic [N_RAILS-1:0] off_mask,
  output logic               finished
);
  localparam int unsigned IDW = $clog2(N_RAILS);
  localparam int unsigned STW = $clog2(N_RAILS + 1);
  localparam logic [CW-1:0]  GAP_LAST = CW'(GAP - 1);
  localparam logic [STW-1:0] LAST_STEP = STW'(N_RAILS);

  logic [IDW-1:0] step_rail [N_RAILS];
  logic [STW-1:0] step;
  logic [CW-1:0]  gcnt;

  for (genvar s = 0; s < N_RAILS; s++) begin : g_order
    if (MIRROR) begin : g_mirror
      assign step_rail[s] = IDW'(N_RAILS - 1 - s);
    end else begin : g_table
      assign step_rail[s] = ORDER[s*IDW +: IDW];
    end
  end

  assign finished = (step == LAST_STEP);

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      off_mask <= '0;
      step     <= '0;
      gcnt     <= '0;
    end else if (tick && !finished) begin
      if (gcnt == GAP_LAST) begin
        off_mask[step_rail[step[IDW-1:0]]] <= 1'b1;
        step <= step + 1'b1;
        gcnt <= '0;
      end else begin
        gcnt <= gcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rail_sequencer.sv
`timescale 1ns/1ps
module rail_sequencer
  import psq_pkg::*;
#(
  parameter int unsigned N_RAILS = 4,
  parameter int unsigned CW      = 8,
  parameter logic [N_RAILS*CW-1:0] DELAY_TICKS   = {8'd6, 8'd1, 8'd3, 8'd2},
  parameter logic [N_RAILS*CW-1:0] TIMEOUT_TICKS = {8'd5, 8'd4, 8'd6, 8'd5},
  parameter logic [N_RAILS-1:0]    RELATIVE_MASK = 4'b0110,
  parameter logic [N_RAILS*$clog2(N_RAILS)-1:0] DEP_RAIL = {2'd0, 2'd1, 2'd0, 2'd0},
  parameter logic [N_RAILS-1:0]    REQUIRED      = 4'b0111,
  parameter int unsigned           RELEASE_TICKS = 3,
  parameter int unsigned           PD_GAP_TICKS  = 2,
  parameter logic [N_RAILS*$clog2(N_RAILS)-1:0] PD_ORDER = {2'd0, 2'd1, 2'd3, 2'd2},
  parameter bit                    PD_MIRROR     = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick_ms,
  input  logic                       seq_start,
  input  logic                       seq_shutdown,
  input  logic [N_RAILS-1:0]         rail_pg,
  output logic [N_RAILS-1:0]         rail_en,
  output logic                       sys_rst_n,
  output logic                       fault_timeout,
  output logic [$clog2(N_RAILS)-1:0] fault_rail,
  output logic                       seq_done
);
  localparam int unsigned IDW = $clog2(N_RAILS);

  seq_st_t            st;
  logic [N_RAILS-1:0] en_raw;
  logic [N_RAILS-1:0] to_hit;
  logic [N_RAILS-1:0] off_mask;
  logic               any_to;
  logic [IDW-1:0]     hit_id;
  logic               pd_finished;
  logic               up;

  assign up     = (st == ST_UP);
  assign any_to = |to_hit;

  for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
    localparam logic [IDW-1:0] DI = DEP_RAIL[i*IDW +: IDW];
    psq_rail #(
      .CW      (CW),
      .DELAY   (DELAY_TICKS[i*CW +: CW]),
      .TIMEOUT (TIMEOUT_TICKS[i*CW +: CW]),
      .RELATIVE(RELATIVE_MASK[i])
    ) u_rail (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (st == ST_IDLE),
      .active(up),
      .tick  (tick_ms),
      .dep_pg(rail_pg[DI]),
      .dep_en(rail_en[DI]),
      .own_pg(rail_pg[i]),
      .en_raw(en_raw[i]),
      .to_hit(to_hit[i])
    );
  end

  // lowest index wins when several rails expire on the same tick
  always_comb begin
    hit_id = '0;
    for (int i = N_RAILS - 1; i >= 0; i--) begin
      if (to_hit[i]) hit_id = IDW'(i);
    end
  end

  psq_rstgate #(
    .N_RAILS(N_RAILS),
    .CW     (CW),
    .REQ    (REQUIRED),
    .REL    (RELEASE_TICKS)
  ) u_rstgate (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (up && !any_to && !seq_shutdown),
    .tick (tick_ms),
    .pg   (rail_pg),
    .rel_n(sys_rst_n)
  );

  psq_pdown #(
    .N_RAILS(N_RAILS),
    .CW     (CW),
    .GAP    (PD_GAP_TICKS),
    .ORDER  (PD_ORDER),
    .MIRROR (PD_MIRROR)
  ) u_pdown (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (st == ST_DOWN),
    .tick    (tick_ms),
    .off_mask(off_mask),
    .finished(pd_finished)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= ST_IDLE;
      fault_timeout <= 1'b0;
      fault_rail    <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (seq_start) begin
            st            <= ST_UP;
            fault_timeout <= 1'b0;
            fault_rail    <= '0;
          end
        end
        ST_UP: begin
          if (seq_shutdown) begin
            st <= ST_DOWN;
          end else if (any_to) begin
            st            <= ST_HALT;
            fault_timeout <= 1'b1;
            fault_rail    <= hit_id;
          end
        end
        ST_HALT: if (seq_shutdown) st <= ST_DOWN;
        ST_DOWN: if (pd_finished) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign rail_en  = en_raw & ~off_mask;
  assign seq_done = up && (&rail_en) && sys_rst_n;
endmodule

// File: rtl/psq_checker.sv
`timescale 1ns/1ps
module psq_checker #(
  parameter int unsigned        N_RAILS  = 4,
  parameter logic [N_RAILS-1:0] REQUIRED = '1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_RAILS-1:0] rail_pg,
  input logic [N_RAILS-1:0] rail_en,
  input logic               sys_rst_n,
  input logic               fault_timeout,
  input logic               seq_done
);
  p_release_needs_pg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> $past(&(rail_pg | ~REQUIRED)));

  p_pg_loss_resets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_n && !(&(rail_pg | ~REQUIRED))) |=> !sys_rst_n);

  p_done_consistent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> ((&rail_en) && sys_rst_n));

  p_reset_before_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(rail_en) & ~rail_en)) |-> !$past(sys_rst_n));

  p_single_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones($past(rail_en) & ~rail_en) <= 1);

  p_fault_holds_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_timeout |-> !sys_rst_n);

  p_no_rise_after_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rail_en & ~$past(rail_en))) |-> !$past(fault_timeout));
endmodule

bind rail_sequencer psq_checker #(
  .N_RAILS (N_RAILS),
  .REQUIRED(REQUIRED)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rail_pg      (rail_pg),
  .rail_en      (rail_en),
  .sys_rst_n    (sys_rst_n),
  .fault_timeout(fault_timeout),
  .seq_done     (seq_done)
);

// File: tb/rail_sequencer_test.sv
`timescale 1ns/1ps
module rail_sequencer_test;
  localparam int N   = 4;
  localparam int INF = 100000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick_ms = 1'b0;
  logic         seq_start = 1'b0;
  logic         seq_shutdown = 1'b0;
  logic [N-1:0] rail_pg = '0;
  logic [N-1:0] rail_en;
  logic         sys_rst_n;
  logic         fault_timeout;
  logic [1:0]   fault_rail;
  logic         seq_done;

  rail_sequencer uut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .seq_start(seq_start),
    .seq_shutdown(seq_shutdown), .rail_pg(rail_pg), .rail_en(rail_en),
    .sys_rst_n(sys_rst_n), .fault_timeout(fault_timeout),
    .fault_rail(fault_rail), .seq_done(seq_done)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  int age [N];
  int lat [N];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick1();
    @(negedge clk) tick_ms = 1'b1;
    @(negedge clk) tick_ms = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // rail model: good power arrives lat[i] ticks after the enable is seen
  task automatic emulate();
    for (int i = 0; i < N; i++) begin
      if (rail_en[i]) begin
        if (!rail_pg[i]) begin
          if (age[i] == lat[i]) rail_pg[i] = 1'b1;
          else age[i]++;
        end
      end else begin
        rail_pg[i] = 1'b0;
        age[i] = 0;
      end
    end
  endtask

  task automatic run_case(input int l0, input int l1, input bit special);
    int e[N];
    int p0, p1, p2, flt, fid, rel, last, expm, snap, m;
    int seq_ord[N];
    seq_ord = '{2, 3, 1, 0};
    lat = '{l0, l1, 1, 1};
    for (int i = 0; i < N; i++) age[i] = 0;
    rail_pg = '0;
    flt = INF; fid = 0; rel = INF;
    e[0] = 2; e[3] = 6; e[1] = INF; e[2] = INF;
    p0 = e[0] + l0;
    if (l0 >= 5) begin
      flt = e[0] + 5; fid = 0;
    end else begin
      e[1] = p0 + 3;
      p1 = e[1] + l1;
      if (l1 >= 4) begin
        flt = e[1] + 4; fid = 2;
      end else begin
        e[2] = p1 + 1;
        p2 = e[2] + 1;
        rel = p2 + 3;
      end
    end
    last = (flt == INF) ? rel + 2 : flt + 2;

    @(negedge clk) seq_start = 1'b1;
    @(negedge clk) seq_start = 1'b0;
    repeat (3) @(negedge clk);

    for (int k = 1; k <= last; k++) begin
      tick1();
      expm = 0;
      for (int i = 0; i < N; i++)
        if (e[i] <= k && e[i] <= flt) expm |= (1 << i);
      // R1 absolute rails 0 and 3, R2 relative rails 1 and 2
      chk("R1 R2 enable vector", int'(rail_en), expm);
      chk("R5 reset release", int'(sys_rst_n), int'(k >= rel));
      chk("R7 done", int'(seq_done), int'(k >= rel && k >= e[3]));
      chk((fid == 2) ? "R3 wait timeout flag" : "R4 timeout flag",
          int'(fault_timeout), int'(k >= flt));
      if (k >= flt) chk("R4 timeout rail id", int'(fault_rail), fid);
      emulate();
    end

    if (special) begin
      rail_pg[3] = 1'b0;
      tick1();
      chk("R5 non-required rail ignored", int'(sys_rst_n), 1);
      rail_pg[3] = 1'b1;
      @(negedge clk) rail_pg[1] = 1'b0;
      @(negedge clk);
      chk("R6 pg loss asserts reset", int'(sys_rst_n), 0);
      chk("R7 done drops with reset", int'(seq_done), 0);
      rail_pg[1] = 1'b1;
      tick1();
      chk("R6 window restarts", int'(sys_rst_n), 0);
      tick1();
      chk("R6 window restarts", int'(sys_rst_n), 0);
      tick1();
      chk("R6 release after full window", int'(sys_rst_n), 1);
      chk("R7 done back", int'(seq_done), 1);
    end

    snap = int'(rail_en);
    @(negedge clk) seq_shutdown = 1'b1;
    @(negedge clk) seq_shutdown = 1'b0;
    chk("R8 reset asserted first", int'(sys_rst_n), 0);
    chk("R8 enables held at request", int'(rail_en), snap);
    for (int j = 1; j <= 2 * N; j++) begin
      tick1();
      m = snap;
      for (int s = 0; s < j / 2; s++) m &= ~(1 << seq_ord[s]);
      chk("R8 ordered drop", int'(rail_en), m);
      chk("R8 reset held in shutdown", int'(sys_rst_n), 0);
      emulate();
    end
    repeat (2) @(negedge clk);
    chk("R8 idle after shutdown", int'(seq_done), 0);
    chk("R10 fault flag sticky", int'(fault_timeout), int'(flt != INF));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset enables", int'(rail_en), 0);
    chk("R9 reset sys reset", int'(sys_rst_n), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 enables after reset", int'(rail_en), 0);
    chk("R9 sys reset after reset", int'(sys_rst_n), 0);
    chk("R9 fault after reset", int'(fault_timeout), 0);
    chk("R9 done after reset", int'(seq_done), 0);
    run_case(1, 1, 1'b1);
    for (int a = 1; a <= 5; a++)
      for (int b = 1; b <= 4; b++)
        run_case(a, b, 1'b0);
    // R10: the next start clears the sticky fault
    run_case(2, 2, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule